// File: doc/BRIEF.md
# Secure Boot State Monitor

This block holds the chip's security state and moves it one way only, toward lower trust. After reset it sits in a Check state. It waits there until the boot-validation logic reports a result, then moves to Trusted or to Non-Secure. After that, software commands and hardware violation inputs can demote it to Soft Fail. From Soft Fail, software may step it down to Non-Secure. Trusted can only be reached again through a reset.

Software reaches the block through a small register port with two words. One is a command word whose bits act as write-one trigger pulses. The other is a status word that carries the 4-bit state code. Every state change shows up on the next read of the status word, so a software polling loop ends within a read or two. A current-state output and a one-cycle change pulse let neighbouring hardware follow the state without using the bus.

Top module: `sec_state_mon`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it drops, the state is Check (code 0x9) and `state_evt` is low. The state code is always one of 0x9, 0xD, 0xB, 0x3.
- R2: In Check, a clock edge that samples `boot_done` high moves the state to Trusted (0xD) if `boot_ok` is 1, or to Non-Secure (0xB) if it is 0. The new code is on `state_code` right after that edge.
- R3: A read with `rd_en` high at byte address 0x14 returns the state code in bits 11:8 of `rdata` on the edge after the request, with every other bit zero. A read of address 0x04 or of any other address returns zero, and `rdata` is zero in any cycle with no read.
- R4: In Trusted, a write to address 0x04 with bit 8 set moves the state to Soft Fail (0x3) at that edge.
- R5: In Soft Fail, a write to address 0x04 with bit 0 set moves the state to Non-Secure. Soft Fail leaves only toward Non-Secure.
- R6: In Trusted or in Non-Secure, a write to address 0x04 with bit 9 set moves the state to Soft Fail at that edge.
- R7: Any bit of `hw_viol` sampled high moves Trusted or Non-Secure to Soft Fail. It has no effect in Check or in Soft Fail.
- R8: A command that is not legal in the current state is ignored. This covers bit 8 in Non-Secure, bit 0 outside Soft Fail, bit 9 in Soft Fail, any command in Check, a write of zero, and a write to an address other than 0x04.
- R9: Trusted is entered only from Check. No path leads back to Trusted without a reset.
- R10: `state_evt` is high for exactly the one cycle after each edge on which the state code changed, and low otherwise.
- R11: `boot_done` has no effect in any state other than Check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| boot_done | input | 1 | Boot validation finished strobe |
| boot_ok | input | 1 | Boot validation result, 1 = success |
| hw_viol | input | N_HWV | Hardware security violation inputs |
| state_code | output | 4 | Current 4-bit state code |
| state_evt | output | 1 | One-cycle pulse after a state change |

## Verification
On every cycle the assertions check the following. The state code is always legal. Trusted is only entered from Check, and Soft Fail only exits to Non-Secure. A hardware violation or a fatal command in Trusted or Non-Secure always lands in Soft Fail. The change pulse matches a change in state exactly. Status read data never carries bits outside 11:8. Only the bench's scenarios can show that each illegal or misaddressed command leaves the state unchanged, that boot results are taken only in Check, and that read data shows the right code one edge after the request.

// File: rtl/sec_state_pkg.sv
package sec_state_pkg;

  // 4-bit state codes, reported in bits 11:8 of the status word
  typedef enum logic [3:0] {
    ST_CHECK   = 4'h9,
    ST_TRUSTED = 4'hD,
    ST_NONSEC  = 4'hB,
    ST_SOFTF   = 4'h3
  } sec_state_t;

  // command word bit positions
  localparam int CMD_ADV_BIT = 0;  // step Soft Fail -> Non-Secure
  localparam int CMD_SV_BIT  = 8;  // software violation
  localparam int CMD_FSV_BIT = 9;  // fatal software violation

  // status word field placement
  localparam int STAT_LSB = 8;
  localparam int STAT_W   = 4;

endpackage

// File: rtl/sec_state_regs.sv
module sec_state_regs
  import sec_state_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h04,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STAT_W-1:0] cur_code,
  output logic              cmd_adv,
  output logic              cmd_sv,
  output logic              cmd_fsv,
  output logic [DATA_W-1:0] rdata
);

  localparam int HI_PAD = DATA_W - STAT_LSB - STAT_W;

  logic cmd_hit;
  logic stat_hit;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign cmd_hit  = wr_en && (addr == CMD_OFS);
  assign stat_hit = rd_en && (addr == STAT_OFS);

  // write-one trigger pulses; nothing is stored, so they self-clear
  assign cmd_adv = cmd_hit && wdata[CMD_ADV_BIT];
  assign cmd_sv  = cmd_hit && wdata[CMD_SV_BIT];
  assign cmd_fsv = cmd_hit && wdata[CMD_FSV_BIT];

  assign unused_wdata = ^{wdata[DATA_W-1:CMD_FSV_BIT+1],
                          wdata[CMD_SV_BIT-1:CMD_ADV_BIT+1]};

  assign rd_mux = stat_hit ? {{HI_PAD{1'b0}}, cur_code, {STAT_LSB{1'b0}}}
                           : '0;

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

endmodule

// File: rtl/sec_state_fsm.sv
module sec_state_fsm
  import sec_state_pkg::*;
#(
  parameter int N_HWV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_done,
  input  logic             boot_ok,
  input  logic [N_HWV-1:0] hw_viol,
  input  logic             cmd_adv,
  input  logic             cmd_sv,
  input  logic             cmd_fsv,
  output sec_state_t       cur,
  output logic             evt
);

  sec_state_t nxt;
  logic viol_any;

  assign viol_any = |hw_viol;

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_CHECK:   if (boot_done) nxt = boot_ok ? ST_TRUSTED : ST_NONSEC;
      ST_TRUSTED: if (viol_any || cmd_sv || cmd_fsv) nxt = ST_SOFTF;
      ST_NONSEC:  if (viol_any || cmd_fsv) nxt = ST_SOFTF;
      ST_SOFTF:   if (cmd_adv) nxt = ST_NONSEC;
      default:    nxt = ST_SOFTF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= ST_CHECK;
      evt <= 1'b0;
    end else begin
      cur <= nxt;
      evt <= (nxt != cur);
    end
  end

endmodule

// File: rtl/sec_state_mon.sv
module sec_state_mon
  import sec_state_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N_HWV  = 4,
  parameter logic [ADDR_W-1:0] CMD_OFS  = 'h04,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              boot_done,
  input  logic              boot_ok,
  input  logic [N_HWV-1:0]  hw_viol,
  output logic [3:0]        state_code,
  output logic              state_evt
);

  localparam int DATA_W = 32;

  logic       cmd_adv, cmd_sv, cmd_fsv;
  sec_state_t cur;

  sec_state_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CMD_OFS(CMD_OFS), .STAT_OFS(STAT_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .cur_code(cur),
    .cmd_adv(cmd_adv), .cmd_sv(cmd_sv), .cmd_fsv(cmd_fsv),
    .rdata(rdata)
  );

  sec_state_fsm #(.N_HWV(N_HWV)) u_fsm (
    .clk(clk), .rst(rst), .boot_done(boot_done), .boot_ok(boot_ok),
    .hw_viol(hw_viol), .cmd_adv(cmd_adv), .cmd_sv(cmd_sv),
    .cmd_fsv(cmd_fsv), .cur(cur), .evt(state_evt)
  );

  assign state_code = cur;

endmodule

// File: rtl/sec_state_mon_chk.sv
module sec_state_mon_chk #(
  parameter int ADDR_W = 8,
  parameter int N_HWV  = 4,
  parameter logic [ADDR_W-1:0] CMD_OFS = 'h04
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [N_HWV-1:0]  hw_viol,
  input logic [3:0]        state_code,
  input logic              state_evt
);

  // R1
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'h9 || state_code == 4'hD ||
     state_code == 4'hB || state_code == 4'h3));

  // R9
  trusted_from_check_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 4'hD && $past(state_code) != 4'hD) |->
      $past(state_code) == 4'h9);

  // R5
  softfail_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code != 4'h3 && $past(state_code) == 4'h3) |->
      state_code == 4'hB);

  // R7
  hw_viol_demote_chk: assert property (@(posedge clk) disable iff (rst)
    ((|hw_viol) && (state_code == 4'hD || state_code == 4'hB)) |=>
      state_code == 4'h3);

  // R6
  fatal_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CMD_OFS && wdata[9] &&
     (state_code == 4'hD || state_code == 4'hB)) |=> state_code == 4'h3);

  // R10
  evt_matches_change_chk: assert property (@(posedge clk) disable iff (rst)
    state_evt == (state_code != $past(state_code)));

  // R3
  rdata_field_only_chk: assert property (@(posedge clk) disable iff (rst)
    rdata[31:12] == '0 && rdata[7:0] == '0);

endmodule

bind sec_state_mon sec_state_mon_chk #(
  .ADDR_W(ADDR_W), .N_HWV(N_HWV), .CMD_OFS(CMD_OFS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .hw_viol(hw_viol), .state_code(state_code),
  .state_evt(state_evt)
);

// File: tb/sec_state_mon_bench.sv
module sec_state_mon_bench;

  localparam int ADDR_W = 8;
  localparam int N_HWV  = 4;
  localparam logic [3:0] C_CHK = 4'h9, C_TRU = 4'hD, C_NS = 4'hB, C_SF = 4'h3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic boot_done = 1'b0, boot_ok = 1'b0;
  logic [N_HWV-1:0] hw_viol = '0;
  logic [3:0] state_code;
  logic state_evt;

  always #2 clk = ~clk;

  sec_state_mon u_sec_state_mon (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .boot_done(boot_done), .boot_ok(boot_ok),
    .hw_viol(hw_viol), .state_code(state_code), .state_evt(state_evt)
  );

  typedef struct {
    bit          is_read;
    logic [31:0] exp_data;
    logic [3:0]  exp_code;
    logic        exp_evt;
    string       tag;
  } item_t;

  item_t sb[$];
  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  // monitor: one queued expectation per negative edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      n_tests++;
      if (it.is_read) begin
        if (rdata !== it.exp_data) begin
          n_fail++;
          $display("FAIL %s: rdata=%h expected %h", it.tag, rdata, it.exp_data);
        end
      end else if (state_code !== it.exp_code || state_evt !== it.exp_evt) begin
        n_fail++;
        $display("FAIL %s: code=%h evt=%b expected code=%h evt=%b",
                 it.tag, state_code, state_evt, it.exp_code, it.exp_evt);
      end
    end
  end

  task automatic push_state(input logic [3:0] c, input logic e, input string t);
    item_t it;
    it.is_read = 0; it.exp_data = '0; it.exp_code = c; it.exp_evt = e; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic finish_cycle();
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; boot_done = 0; boot_ok = 0; hw_viol = '0;
    addr = '0; wdata = '0;
  endtask

  task automatic do_reset(input string t);
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    push_state(C_CHK, 1'b0, t);
    @(negedge clk);
  endtask

  task automatic idle(input logic [3:0] c, input logic e, input string t);
    finish_cycle();
    push_state(c, e, t);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic [3:0] c, input logic e, input string t);
    wr_en = 1; addr = a; wdata = d;
    finish_cycle();
    push_state(c, e, t);
  endtask

  task automatic boot(input logic ok, input logic [3:0] c, input logic e,
                      input string t);
    boot_done = 1; boot_ok = ok;
    finish_cycle();
    push_state(c, e, t);
  endtask

  task automatic viol(input logic [N_HWV-1:0] v, input logic [3:0] c,
                      input logic e, input string t);
    hw_viol = v;
    finish_cycle();
    push_state(c, e, t);
  endtask

  task automatic rd(input logic en, input logic [7:0] a,
                    input logic [31:0] exp, input string t);
    item_t it;
    rd_en = en; addr = a;
    finish_cycle();
    it.is_read = 1; it.exp_data = exp; it.exp_code = '0; it.exp_evt = 0; it.tag = t;
    sb.push_back(it);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset("R1 reset state");
    idle(C_CHK, 0, "R1 idle in check");
    rd(1, 8'h14, 32'h900, "R3 status check code");
    wr(8'h04, 32'h301, C_CHK, 0, "R8 commands ignored in check");
    viol(4'b0010, C_CHK, 0, "R7 hw violation ignored in check");
    boot(1, C_TRU, 1, "R2 boot ok to trusted");
    idle(C_TRU, 0, "R10 pulse lasts one cycle");
    rd(1, 8'h14, 32'hD00, "R3 status trusted code");
    rd(1, 8'h04, 32'h0, "R3 command word reads zero");
    rd(1, 8'h08, 32'h0, "R3 unmapped reads zero");
    rd(0, 8'h14, 32'h0, "R3 no read gives zero");
    wr(8'h04, 32'h0, C_TRU, 0, "R8 write of zero ignored");
    wr(8'h04, 32'h1, C_TRU, 0, "R8 step bit ignored in trusted");
    wr(8'h14, 32'h100, C_TRU, 0, "R8 wrong address ignored");
    boot(0, C_TRU, 0, "R11 boot result ignored in trusted");
    wr(8'h04, 32'h100, C_SF, 1, "R4 violation bit to soft fail");
    rd(1, 8'h14, 32'h300, "R3 status soft fail code");
    viol(4'b1000, C_SF, 0, "R7 hw violation ignored in soft fail");
    wr(8'h04, 32'h200, C_SF, 0, "R8 fatal bit ignored in soft fail");
    wr(8'h04, 32'h1, C_NS, 1, "R5 step bit to non-secure");
    wr(8'h04, 32'h100, C_NS, 0, "R8 violation bit ignored in non-secure");
    boot(1, C_NS, 0, "R9 R11 no return to trusted");
    rd(1, 8'h14, 32'hB00, "R3 status non-secure code");
    wr(8'h04, 32'h200, C_SF, 1, "R6 fatal from non-secure");
    wr(8'h04, 32'h1, C_NS, 1, "R5 step again");
    viol(4'b0001, C_SF, 1, "R7 hw violation from non-secure");
    idle(C_SF, 0, "R10 no pulse when steady");

    do_reset("R1 reset after soft fail");
    boot(0, C_NS, 1, "R2 boot fail to non-secure");
    wr(8'h04, 32'h1, C_NS, 0, "R8 step bit ignored in non-secure");

    do_reset("R1 reset again");
    boot(1, C_TRU, 1, "R2 boot ok second run");
    wr(8'h04, 32'h200, C_SF, 1, "R6 fatal from trusted");

    do_reset("R1 reset third run");
    boot(1, C_TRU, 1, "R2 boot ok third run");
    viol(4'b0100, C_SF, 1, "R7 hw violation from trusted");
    wr(8'h04, 32'h1, C_NS, 1, "R5 step after hw violation");

    repeat (3) @(posedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule